// File: doc/BRIEF.md
# GPIO Interrupt Controller

This block drives and samples up to 32 general-purpose pins on behalf of a processor. Through a simple 32-bit register bus it sets the output value and the output enable of each pin, and reads the pin levels back after they pass through a synchronizer. Each pin can raise an interrupt in two independent ways. The first is a live level condition with a programmable active level. The second is a sticky edge event on a programmable edge direction, which software clears by writing ones.

All pending sources are OR-reduced into one summary status bit. A single summary enable bit then gates that status bit onto the interrupt output. Software reads the summary register, then the event register, to find the source. It clears edge sources by writing ones and clears level sources by removing the condition or masking it. Bus reads are combinational: `bus_rdata` reflects the addressed register in the same cycle as `bus_valid` with `bus_we` low, and is zero otherwise. Writes take effect at the clock edge that samples `bus_valid` and `bus_we` high.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every control register reads zero, `pin_out` and `pin_oe` are zero and `irq` is low.
- R2: Byte address 0x44 holds the output value and 0x48 the output enable. `pin_oe` equals the enable register. `pin_out[i]` equals the output value bit AND the enable bit, so a disabled pin drives 0. Writes show on the pins at the clock edge that captures them.
- R3: Address 0x40 reads the pin levels after SYNC_STAGES (default 2) clock edges. Writes to it are ignored.
- R4: Address 0x54 enables level sensing per pin. At address 0x50, a polarity bit of 1 means active-low and 0 means active-high. Level pending for a pin is (synchronized input XOR polarity) AND enable, and it follows the pin and the registers live, with no latching.
- R5: Address 0x64 selects the edge per pin: 0 means rising and 1 means falling. A selected edge on the synchronized input sets the pin's bit in the event register at 0x58. The bit is set whether or not the pin's event enable is set, and it is visible no later than three clock edges after the pin changes. An edge of the other direction sets nothing.
- R6: Writing 1 to a bit of 0x58 clears that event. Writing 0 leaves the bit as it is. If a new selected edge arrives in the cycle of the clearing write, the bit stays set.
- R7: Address 0x5C holds the event enable. Edge pending for a pin is its event bit AND its event enable bit.
- R8: Bit 0 of address 0x00 reads 1 exactly when any pin has a level or edge interrupt pending. All other bits read 0, and writes to this address are ignored.
- R9: Bit 0 of address 0x04 is the summary enable. `irq` is high exactly when summary status bit 0 and the summary enable are both 1.
- R10: Reads of unmapped addresses return zero. So do reads of register bits at or above NUM_PINS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when no read |
| pin_in | input | NUM_PINS (16) | Asynchronous pin levels |
| pin_out | output | NUM_PINS (16) | Driven pin values |
| pin_oe | output | NUM_PINS (16) | Per-pin output enable |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a clearing write that lands in the same cycle as a new selected edge on the same pin. To produce it, the bench first latches an event on the pin. It then raises the pin again and counts the synchronizer and edge-detect registers, so that the clearing write is captured on exactly the edge at which the edge detector fires. The bench also reads an event that latched while its enable was off, and then shows that it reaches the summary bit only once the enable is set.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   localparam int unsigned WORD_W = 32;

   typedef logic [WORD_W-1:0] word_t;

   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_SUMMARY,
      SEL_SUM_EN,
      SEL_PIN_IN,
      SEL_DOUT,
      SEL_DOE,
      SEL_LVL_POL,
      SEL_LVL_EN,
      SEL_EVT,
      SEL_EVT_EN,
      SEL_EVT_POL
   } reg_sel_e;

   // Byte offsets seen by software
   localparam logic [7:0] OFS_SUMMARY = 8'h00;
   localparam logic [7:0] OFS_SUM_EN  = 8'h04;
   localparam logic [7:0] OFS_PIN_IN  = 8'h40;
   localparam logic [7:0] OFS_DOUT    = 8'h44;
   localparam logic [7:0] OFS_DOE     = 8'h48;
   localparam logic [7:0] OFS_LVL_POL = 8'h50;
   localparam logic [7:0] OFS_LVL_EN  = 8'h54;
   localparam logic [7:0] OFS_EVT     = 8'h58;
   localparam logic [7:0] OFS_EVT_EN  = 8'h5C;
   localparam logic [7:0] OFS_EVT_POL = 8'h64;

   function automatic reg_sel_e decode_addr(input logic [7:0] a);
      case (a)
         OFS_SUMMARY: decode_addr = SEL_SUMMARY;
         OFS_SUM_EN:  decode_addr = SEL_SUM_EN;
         OFS_PIN_IN:  decode_addr = SEL_PIN_IN;
         OFS_DOUT:    decode_addr = SEL_DOUT;
         OFS_DOE:     decode_addr = SEL_DOE;
         OFS_LVL_POL: decode_addr = SEL_LVL_POL;
         OFS_LVL_EN:  decode_addr = SEL_LVL_EN;
         OFS_EVT:     decode_addr = SEL_EVT;
         OFS_EVT_EN:  decode_addr = SEL_EVT_EN;
         OFS_EVT_POL: decode_addr = SEL_EVT_POL;
         default:     decode_addr = SEL_NONE;
      endcase
   endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned WIDTH  = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= '0;
            else        chain_q[0] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign sync_o = chain_q[STAGES-1];

   // R3
   first_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> chain_q[0] == $past(async_i));

endmodule

// File: rtl/gpio_edge_event.sv
module gpio_edge_event #(
   parameter int unsigned WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] sync_i,
   input  logic [WIDTH-1:0] fall_sel_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] event_o
);

   logic [WIDTH-1:0] prev_q;
   logic [WIDTH-1:0] event_q;
   logic [WIDTH-1:0] rise;
   logic [WIDTH-1:0] fall;
   logic [WIDTH-1:0] hit;

   always_comb begin
      rise = sync_i & ~prev_q;
      fall = ~sync_i & prev_q;
      hit  = (fall & fall_sel_i) | (rise & ~fall_sel_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= '0;
         event_q <= '0;
      end else begin
         prev_q  <= sync_i;
         event_q <= (event_q & ~clr_i) | hit;
      end
   end

   assign event_o = event_q;

   // R6
   evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      |clr_i |=> ((event_q & $past(clr_i & ~hit)) == '0));

   // R6
   evt_edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      |(clr_i & hit) |=> ((event_q & $past(clr_i & hit)) == $past(clr_i & hit)));

   // R5
   evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((~event_q & $past(event_q & ~clr_i)) == '0));

endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
   import gpio_irq_pkg::*;
#(
   parameter int unsigned WIDTH = 16
) (
   input  reg_sel_e         sel_i,
   input  logic             rd_i,
   input  logic             summary_i,
   input  logic             sum_en_i,
   input  logic [WIDTH-1:0] pin_i,
   input  logic [WIDTH-1:0] dout_i,
   input  logic [WIDTH-1:0] doe_i,
   input  logic [WIDTH-1:0] lvl_pol_i,
   input  logic [WIDTH-1:0] lvl_en_i,
   input  logic [WIDTH-1:0] evt_i,
   input  logic [WIDTH-1:0] evt_en_i,
   input  logic [WIDTH-1:0] evt_pol_i,
   output word_t            rdata_o
);

   word_t sel_word;

   always_comb begin
      unique case (sel_i)
         SEL_SUMMARY: sel_word = word_t'(summary_i);
         SEL_SUM_EN:  sel_word = word_t'(sum_en_i);
         SEL_PIN_IN:  sel_word = word_t'(pin_i);
         SEL_DOUT:    sel_word = word_t'(dout_i);
         SEL_DOE:     sel_word = word_t'(doe_i);
         SEL_LVL_POL: sel_word = word_t'(lvl_pol_i);
         SEL_LVL_EN:  sel_word = word_t'(lvl_en_i);
         SEL_EVT:     sel_word = word_t'(evt_i);
         SEL_EVT_EN:  sel_word = word_t'(evt_en_i);
         SEL_EVT_POL: sel_word = word_t'(evt_pol_i);
         default:     sel_word = '0;
      endcase
      rdata_o = rd_i ? sel_word : '0;
   end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 16,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_valid,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic                irq
);

   localparam int unsigned W = NUM_PINS;

   if (NUM_PINS < 1 || NUM_PINS > WORD_W) begin : g_bad_pins
      $error("gpio_irq_ctrl: NUM_PINS must lie in 1..32");
   end
   if (ADDR_W != 8) begin : g_bad_addr
      $error("gpio_irq_ctrl: ADDR_W must be 8");
   end

   reg_sel_e     sel;
   logic         wr;
   logic         rd;
   logic [W-1:0] wbits;
   logic [W-1:0] pin_sync;
   logic [W-1:0] dout_q, doe_q, lvl_pol_q, lvl_en_q, evt_en_q, evt_pol_q;
   logic         sum_en_q;
   logic [W-1:0] evt_clr;
   logic [W-1:0] evt;
   logic [W-1:0] lvl_pend;
   logic [W-1:0] edge_pend;
   logic         summary;

   assign sel   = decode_addr(bus_addr);
   assign wr    = bus_valid & bus_we;
   assign rd    = bus_valid & ~bus_we;
   assign wbits = bus_wdata[W-1:0];

   gpio_in_sync #(.WIDTH(W), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (pin_in),
      .sync_o  (pin_sync)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q    <= '0;
         doe_q     <= '0;
         lvl_pol_q <= '0;
         lvl_en_q  <= '0;
         evt_en_q  <= '0;
         evt_pol_q <= '0;
         sum_en_q  <= 1'b0;
      end else if (wr) begin
         case (sel)
            SEL_DOUT:    dout_q    <= wbits;
            SEL_DOE:     doe_q     <= wbits;
            SEL_LVL_POL: lvl_pol_q <= wbits;
            SEL_LVL_EN:  lvl_en_q  <= wbits;
            SEL_EVT_EN:  evt_en_q  <= wbits;
            SEL_EVT_POL: evt_pol_q <= wbits;
            SEL_SUM_EN:  sum_en_q  <= bus_wdata[0];
            default:     ;
         endcase
      end
   end

   assign evt_clr = (wr && sel == SEL_EVT) ? wbits : '0;

   gpio_edge_event #(.WIDTH(W)) u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .sync_i     (pin_sync),
      .fall_sel_i (evt_pol_q),
      .clr_i      (evt_clr),
      .event_o    (evt)
   );

   assign lvl_pend  = (pin_sync ^ lvl_pol_q) & lvl_en_q;
   assign edge_pend = evt & evt_en_q;
   assign summary   = |(lvl_pend | edge_pend);
   assign irq       = summary & sum_en_q;
   assign pin_oe    = doe_q;
   assign pin_out   = dout_q & doe_q;

   gpio_rd_mux #(.WIDTH(W)) u_rd (
      .sel_i     (sel),
      .rd_i      (rd),
      .summary_i (summary),
      .sum_en_i  (sum_en_q),
      .pin_i     (pin_sync),
      .dout_i    (dout_q),
      .doe_i     (doe_q),
      .lvl_pol_i (lvl_pol_q),
      .lvl_en_i  (lvl_en_q),
      .evt_i     (evt),
      .evt_en_i  (evt_en_q),
      .evt_pol_i (evt_pol_q),
      .rdata_o   (bus_rdata)
   );

   // R1
   reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0 && !irq));

   // R2
   oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_out & ~pin_oe) == '0));

   // R9
   irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> sum_en_q);

   // R9
   sum_en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == SEL_SUM_EN) |=> (sum_en_q == $past(bus_wdata[0])));

   // R10
   unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && sel == SEL_NONE) |-> (bus_rdata == '0));

endmodule

// File: tb/tb_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_irq_ctrl;
   import gpio_irq_pkg::*;

   localparam int unsigned NP = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_valid = 1'b0;
   logic          bus_we = 1'b0;
   logic [7:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out;
   logic [NP-1:0] pin_oe;
   logic          irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #2.5 clk = ~clk;

   gpio_irq_ctrl #(.NUM_PINS(NP)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_valid (bus_valid),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe),
      .irq       (irq)
   );

   // Monitor: compares each read against the next scoreboard entry
   always @(negedge clk) begin
      if (bus_valid && !bus_we) begin
         checks++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL %s unexpected read: actual=%h expected=none", "scoreboard", bus_rdata);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (bus_rdata !== e) begin
               fails++;
               $display("FAIL %s addr=%h actual=%h expected=%h", t, bus_addr, bus_rdata, e);
            end
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_valid = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
      @(posedge clk); #1;
      exp_q.push_back(e);
      tag_q.push_back(t);
      bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(posedge clk); #1;
      bus_valid = 1'b0;
   endtask

   task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
      checks++;
      if (act !== e) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", t, act, e);
      end
   endtask

   task automatic finish_run();
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL scoreboard leftover: actual=%0d expected=0", exp_q.size());
      end
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      chk(32'(pin_out), 0, "R1 pin_out");
      chk(32'(pin_oe), 0, "R1 pin_oe");
      chk(32'(irq), 0, "R1 irq");
      rd(OFS_DOUT, 0, "R1 dout");
      rd(OFS_DOE, 0, "R1 doe");
      rd(OFS_LVL_EN, 0, "R1 lvl_en");
      rd(OFS_EVT, 0, "R1 evt");
      rd(OFS_SUM_EN, 0, "R1 sum_en");

      // R5 rising edge latches even when its enable is off
      pin_in = 16'h0001; tick(3);
      rd(OFS_EVT, 32'h1, "R5 rise latched");
      rd(OFS_SUMMARY, 0, "R7 masked edge");
      wr(OFS_EVT_EN, 32'h1);
      rd(OFS_SUMMARY, 1, "R8 summary set");
      chk(32'(irq), 0, "R9 irq gated");
      wr(OFS_SUM_EN, 32'h1);
      chk(32'(irq), 1, "R9 irq raised");

      // R5 falling edge ignored under rising selection
      pin_in = 16'h0000; tick(3);
      rd(OFS_EVT, 32'h1, "R5 fall ignored");

      // R6 new edge in the same cycle as the clearing write wins
      pin_in = 16'h0001; tick(1);
      wr(OFS_EVT, 32'h1);
      rd(OFS_EVT, 32'h1, "R6 edge wins");
      wr(OFS_EVT, 32'h1);
      rd(OFS_EVT, 0, "R6 cleared");
      chk(32'(irq), 0, "R9 irq dropped");

      // R6 zeros leave other events alone
      pin_in = 16'h0007; tick(3);
      rd(OFS_EVT, 32'h6, "R5 two pins");
      wr(OFS_EVT, 32'h2);
      rd(OFS_EVT, 32'h4, "R6 partial clear");
      wr(OFS_EVT, 32'h4);

      // R5 falling selection
      wr(OFS_EVT_POL, 32'h20);
      pin_in = 16'h0027; tick(3);
      rd(OFS_EVT, 0, "R5 rise ignored falling");
      pin_in = 16'h0007; tick(3);
      rd(OFS_EVT, 32'h20, "R5 fall latched");
      wr(OFS_EVT, 32'hFFFF_FFFF);
      wr(OFS_EVT_EN, 0);

      // R4 level sensing, live polarity
      wr(OFS_LVL_EN, 32'h8);
      rd(OFS_SUMMARY, 0, "R4 inactive high");
      pin_in = 16'h000F; tick(3);
      rd(OFS_SUMMARY, 1, "R4 active high");
      chk(32'(irq), 1, "R9 level irq");
      wr(OFS_LVL_POL, 32'h8);
      rd(OFS_SUMMARY, 0, "R4 polarity flip");
      chk(32'(irq), 0, "R4 irq after flip");
      pin_in = 16'h0007; tick(3);
      rd(OFS_SUMMARY, 1, "R4 active low");
      wr(OFS_LVL_EN, 0);
      rd(OFS_SUMMARY, 0, "R4 masked");

      // R3 input register, read only
      rd(OFS_PIN_IN, 32'h7, "R3 pins");
      wr(OFS_PIN_IN, 32'hFFFF);
      rd(OFS_PIN_IN, 32'h7, "R3 write ignored");
      pin_in = 16'hA5A5; tick(3);
      rd(OFS_PIN_IN, 32'hA5A5, "R3 new pattern");

      // R8 status write ignored
      wr(OFS_SUMMARY, 32'hFFFF_FFFF);
      rd(OFS_SUMMARY, 0, "R8 write ignored");
      chk(32'(irq), 0, "R8 irq idle");

      // R2 output path and R10 upper bits
      wr(OFS_DOUT, 32'hFFFF_FFFF);
      chk(32'(pin_out), 0, "R2 disabled pins");
      rd(OFS_DOUT, 32'h0000_FFFF, "R10 upper bits");
      wr(OFS_DOE, 32'h00F0);
      chk(32'(pin_out), 32'h00F0, "R2 enabled pins");
      chk(32'(pin_oe), 32'h00F0, "R2 oe");
      wr(OFS_DOUT, 32'h0030);
      chk(32'(pin_out), 32'h0030, "R2 data change");

      // R10 unmapped addresses
      rd(8'h10, 0, "R10 unmapped 10");
      rd(8'h4C, 0, "R10 unmapped 4C");
      rd(8'h60, 0, "R10 unmapped 60");

      tick(2);
      done = 1'b1;
      finish_run();
   end

endmodule